// File: doc/BRIEF.md
# Multi-Channel Pulse-Per-Second Timestamper and Pulse Placer

This block runs from one fast clock, nominally 100 MHz or more, so that one tick is 10 ns or less. A free-running tick counter is the common timebase. Several asynchronous reference inputs are resynchronised. Each can be scaled down to one event per second by its own programmable divider, or the divider can be bypassed when the input already delivers one pulse per second. Each qualified event latches the current tick count. The record, which carries the channel number and the time, goes into a small show-ahead queue that a host drains.

The host runs its ensemble filter on these records and writes back the tick position of a future output pulse. The block fires its pulse output when the counter reaches the armed position, and holds it high for a programmable number of ticks. A written position is held in a pending slot and is taken up only when the current pulse fires, which gives the loop its one-second latency. If the host writes nothing, the next pulse follows one nominal second after the last one.

Top module: `pps_hub`

## Requirements
- R1: `tick_count` is 0 while `rst_n` is low. It then rises by exactly one per clock and wraps from all-ones to zero.
- R2: A rising edge of `ref_in[c]` that is first sampled high at clock edge e produces one record, whose time equals the `tick_count` value held between edges e+1 and e+2. With no contention the record appears at the queue head after edge e+3. A level that stays high produces no further records.
- R3: Each channel has a divisor that is loaded through `div_wr`/`div_sel`/`div_val`. The divisor resets to 0. A divisor of 0 or 1 passes every rising edge. A divisor N of 2 or more produces an event on every Nth rising edge, counted from the divisor write.
- R4: The queue is show-ahead. While `ts_valid` is high, `ts_chan`/`ts_time` show the oldest record, and `ts_rd` removes it on the next edge. A read while the queue is empty is ignored. The queue holds DEPTH records.
- R5: Events on several channels in the same clock get the same time and enter the queue one per clock, in ascending channel order.
- R6: `ts_ovf` is sticky. It is set when a record finds the queue full, or when a channel fires again before its previous record has been queued. `ovf_clr` clears it, and a new loss in the same clock wins over the clear.
- R7: When `tick_count` equals the armed position, `pps_out` is high from the next clock onward for the current width, in ticks. The width resets to DEF_WIDTH. A width of 0 gives no pulse.
- R8: The armed position resets to SEC_TICKS. At each firing it is re-armed to the last position the host wrote since the previous firing, or, if nothing was written, to the old position plus SEC_TICKS modulo 2^TW.
- R9: A width write affects the next pulse only. It neither stretches nor cuts a pulse that is already in progress.
- R10: Under reset, `ts_valid`, `ts_ovf` and `pps_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast tick clock |
| rst_n | input | 1 | synchronous active-low reset |
| ref_in | input | N_CH | asynchronous reference inputs |
| div_wr | input | 1 | divisor write strobe |
| div_sel | input | CH_W | channel addressed by the divisor write |
| div_val | input | PRE_W | divisor value (0 = bypass) |
| ts_rd | input | 1 | remove queue head |
| ovf_clr | input | 1 | clear the sticky overflow flag |
| place_wr | input | 1 | output placement write strobe |
| place_val | input | TW | tick position of a future output pulse |
| width_wr | input | 1 | pulse width write strobe |
| width_val | input | WID_W | pulse width in ticks |
| ts_valid | output | 1 | queue holds at least one record |
| ts_chan | output | CH_W | channel of the head record |
| ts_time | output | TW | tick time of the head record |
| ts_ovf | output | 1 | sticky loss flag |
| pps_out | output | 1 | generated pulse |
| tick_count | output | TW | free-running tick counter |

## Verification
A corrupted divider count or a stuck edge detector shows at the queue head within four clocks of the input edge, as a missing, doubled or mistimed record. A holding slot or queue pointer that goes wrong shows as a wrong channel order, a wrong time or a wrong `ts_valid` at the next read. A fault in the armed position or the pending slot shows only when the pulse fires, up to one programmed second later, as a `pps_out` rise at the wrong tick. The reference model is compared against every port on every clock, so each of these faults is caught in the first clock in which it is visible.

// File: rtl/pps_hub_pkg.sv
// Shared helpers for the pulse-per-second hub.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package pps_hub_pkg;

    // Index width for a count of items; never less than one bit.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pps_hub_inport.sv
// One reference channel: two-flop synchroniser, rising-edge detector and
// divide-by-N event qualifier.
// Assumes: ref_i is asynchronous and each level lasts at least one clock.
// A divisor of 0 or 1 passes every edge.
module pps_hub_inport #(
    parameter int unsigned PRE_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_i,
    input  logic             div_we_i,
    input  logic [PRE_W-1:0] div_i,
    output logic             evt_o
);

    logic [2:0]       sync_q;
    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] cnt_q;
    logic             rise;
    logic             at_limit;

    // Bring the input into the clock domain and keep one stage of history.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], ref_i};
    end

    assign rise     = sync_q[1] & ~sync_q[2];
    assign at_limit = (div_q == '0) || (cnt_q == div_q - 1'b1);
    assign evt_o    = rise && at_limit;

    // Hold the divisor and count qualified edges toward it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (div_we_i) begin
            div_q <= div_i;
            cnt_q <= '0;
        end else if (rise) begin
            cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
        end
    end

    // R2
    single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> !evt_o);

endmodule

// File: rtl/pps_hub_tsq.sv
// Timestamp capture and queue. Each channel has a holding slot that latches
// the tick count on its event. A fixed-priority picker moves the lowest
// pending slot into a show-ahead queue, one record per clock.
// Assumes: DEPTH >= 2. Records that find the queue full are dropped and
// flagged.
module pps_hub_tsq #(
    parameter int unsigned N_CH  = 4,
    parameter int unsigned TW    = 32,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CH_W = pps_hub_pkg::idx_width(N_CH),
    localparam int unsigned AW   = pps_hub_pkg::idx_width(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] evt_i,
    input  logic [TW-1:0]   tick_i,
    input  logic            pop_req_i,
    input  logic            clr_i,
    output logic            head_v_o,
    output logic [CH_W-1:0] head_ch_o,
    output logic [TW-1:0]   head_ts_o,
    output logic            ovf_o
);

    logic [N_CH-1:0] hold_v;
    logic [TW-1:0]   hold_ts [N_CH];
    logic [N_CH-1:0] grant;
    logic            push;
    logic [CH_W-1:0] push_ch;
    logic [TW-1:0]   push_ts;
    logic            lost;

    logic [CH_W-1:0] mem_ch [DEPTH];
    logic [TW-1:0]   mem_ts [DEPTH];
    logic [AW-1:0]   wp_q, rp_q;
    logic [AW:0]     cnt_q;
    logic            full, pop, wr;

    // Pick the lowest-numbered pending slot.
    always_comb begin
        grant   = '0;
        push    = 1'b0;
        push_ch = '0;
        push_ts = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (hold_v[i] && !push) begin
                grant[i] = 1'b1;
                push     = 1'b1;
                push_ch  = CH_W'(i);
                push_ts  = hold_ts[i];
            end
        end
    end

    assign lost = |(evt_i & hold_v & ~grant);

    // Latch the arrival time per channel; release the slot once it is picked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v <= '0;
            for (int i = 0; i < N_CH; i++) hold_ts[i] <= '0;
        end else begin
            for (int i = 0; i < N_CH; i++) begin
                if (evt_i[i]) begin
                    hold_v[i]  <= 1'b1;
                    hold_ts[i] <= tick_i;
                end else if (grant[i]) begin
                    hold_v[i]  <= 1'b0;
                end
            end
        end
    end

    assign full = (cnt_q == (AW+1)'(DEPTH));
    assign pop  = pop_req_i && (cnt_q != '0);
    assign wr   = push && !full;

    // Record storage.
    always_ff @(posedge clk) begin
        if (wr) begin
            mem_ch[wp_q] <= push_ch;
            mem_ts[wp_q] <= push_ts;
        end
    end

    // Queue pointers and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr)  wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
            if (pop) rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
            cnt_q <= cnt_q + (AW+1)'(wr) - (AW+1)'(pop);
        end
    end

    // Sticky loss flag; a new loss outranks the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ovf_o <= 1'b0;
        else if ((push && full) || lost) ovf_o <= 1'b1;
        else if (clr_i)                 ovf_o <= 1'b0;
    end

    assign head_v_o  = (cnt_q != '0);
    assign head_ch_o = mem_ch[rp_q];
    assign head_ts_o = mem_ts[rp_q];

    // R4
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= (AW+1)'(DEPTH));

    // R5
    same_time_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && $past(push) && push_ts == $past(push_ts)) |-> push_ch > $past(push_ch));

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_i) |=> ovf_o);

endmodule

// File: rtl/pps_hub_pulsegen.sv
// Output pulse placer. It fires when the tick counter equals the armed
// position and drives the pulse for the programmed width. It re-arms from
// the host's pending placement or, if there is none, from the last position
// plus one nominal second.
// Assumes: the host writes placements at least one firing ahead.
module pps_hub_pulsegen #(
    parameter int unsigned TW        = 32,
    parameter int unsigned SEC_TICKS = 100_000_000,
    parameter int unsigned WID_W     = 16,
    parameter int unsigned DEF_WIDTH = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TW-1:0]    tick_i,
    input  logic             place_we_i,
    input  logic [TW-1:0]    place_i,
    input  logic             width_we_i,
    input  logic [WID_W-1:0] width_i,
    output logic             pulse_o
);

    localparam logic [TW-1:0] STEP = TW'(SEC_TICKS);

    logic [TW-1:0]    next_q;
    logic [TW-1:0]    pend_q;
    logic             pend_v;
    logic [WID_W-1:0] width_q;
    logic [WID_W-1:0] remain_q;
    logic             fire;

    assign fire = (tick_i == next_q);

    // Armed position and the one-deep pending placement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q <= STEP;
            pend_q <= '0;
            pend_v <= 1'b0;
        end else begin
            if (fire) next_q <= pend_v ? pend_q : next_q + STEP;
            if (place_we_i) begin
                pend_q <= place_i;
                pend_v <= 1'b1;
            end else if (fire) begin
                pend_v <= 1'b0;
            end
        end
    end

    // Programmed pulse width.
    always_ff @(posedge clk) begin
        if (!rst_n)          width_q <= WID_W'(DEF_WIDTH);
        else if (width_we_i) width_q <= width_i;
    end

    // Remaining high time of the current pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                remain_q <= '0;
        else if (fire)             remain_q <= width_q;
        else if (remain_q != '0)   remain_q <= remain_q - 1'b1;
    end

    assign pulse_o = (remain_q != '0);

    // R7
    fire_drives_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && width_q != '0) |=> pulse_o);

    // R8
    free_run_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !pend_v) |=> next_q == $past(next_q) + STEP);

    // R8
    host_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && pend_v) |=> next_q == $past(pend_q));

endmodule

// File: rtl/pps_hub.sv
// Top of the hub. Holds the free-running tick counter, one input channel per
// reference, the capture queue and the output pulse placer.
// Assumes: clk is the fast tick clock. The host services the queue faster
// than records arrive on average.
module pps_hub #(
    parameter int unsigned N_CH      = 4,
    parameter int unsigned TW        = 32,
    parameter int unsigned PRE_W     = 32,
    parameter int unsigned DEPTH     = 8,
    parameter int unsigned SEC_TICKS = 100_000_000,
    parameter int unsigned WID_W     = 16,
    parameter int unsigned DEF_WIDTH = 1000,
    localparam int unsigned CH_W     = pps_hub_pkg::idx_width(N_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CH-1:0]  ref_in,
    input  logic             div_wr,
    input  logic [CH_W-1:0]  div_sel,
    input  logic [PRE_W-1:0] div_val,
    input  logic             ts_rd,
    input  logic             ovf_clr,
    input  logic             place_wr,
    input  logic [TW-1:0]    place_val,
    input  logic             width_wr,
    input  logic [WID_W-1:0] width_val,
    output logic             ts_valid,
    output logic [CH_W-1:0]  ts_chan,
    output logic [TW-1:0]    ts_time,
    output logic             ts_ovf,
    output logic             pps_out,
    output logic [TW-1:0]    tick_count
);

    logic [TW-1:0]   tick_q;
    logic [N_CH-1:0] evt;

    // Free-running timebase.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_q + 1'b1;
    end

    assign tick_count = tick_q;

    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        pps_hub_inport #(.PRE_W(PRE_W)) u_in (
            .clk      (clk),
            .rst_n    (rst_n),
            .ref_i    (ref_in[g]),
            .div_we_i (div_wr && (div_sel == CH_W'(g))),
            .div_i    (div_val),
            .evt_o    (evt[g])
        );
    end

    pps_hub_tsq #(.N_CH(N_CH), .TW(TW), .DEPTH(DEPTH)) u_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .tick_i    (tick_q),
        .pop_req_i (ts_rd),
        .clr_i     (ovf_clr),
        .head_v_o  (ts_valid),
        .head_ch_o (ts_chan),
        .head_ts_o (ts_time),
        .ovf_o     (ts_ovf)
    );

    pps_hub_pulsegen #(.TW(TW), .SEC_TICKS(SEC_TICKS), .WID_W(WID_W),
                       .DEF_WIDTH(DEF_WIDTH)) u_pg (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_q),
        .place_we_i (place_wr),
        .place_i    (place_val),
        .width_we_i (width_wr),
        .width_i    (width_val),
        .pulse_o    (pps_out)
    );

    // R1
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q != {TW{1'b1}}) |=> tick_q == $past(tick_q) + 1'b1);

    // R1
    tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q == {TW{1'b1}}) |=> tick_q == '0);

endmodule

// File: tb/pps_hub_test.sv
module pps_hub_test;
    localparam int NCH = 3, TW = 16, PW = 8, DEPTH = 4, SEC = 2000, WW = 8, DEFW = 50;
    localparam int MASK = (1 << TW) - 1;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [NCH-1:0] ref_in = '0;
    logic          div_wr = 0, ts_rd = 0, ovf_clr = 0, place_wr = 0, width_wr = 0;
    logic [1:0]    div_sel = '0;
    logic [PW-1:0] div_val = '0;
    logic [TW-1:0] place_val = '0;
    logic [WW-1:0] width_val = '0;
    logic          ts_valid, ts_ovf, pps_out;
    logic [1:0]    ts_chan;
    logic [TW-1:0] ts_time, tick_count;

    pps_hub #(.N_CH(NCH), .TW(TW), .PRE_W(PW), .DEPTH(DEPTH), .SEC_TICKS(SEC),
              .WID_W(WW), .DEF_WIDTH(DEFW)) uut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .div_wr(div_wr), .div_sel(div_sel),
        .div_val(div_val), .ts_rd(ts_rd), .ovf_clr(ovf_clr), .place_wr(place_wr),
        .place_val(place_val), .width_wr(width_wr), .width_val(width_val),
        .ts_valid(ts_valid), .ts_chan(ts_chan), .ts_time(ts_time), .ts_ovf(ts_ovf),
        .pps_out(pps_out), .tick_count(tick_count));

    int checks = 0, fails = 0;
    bit done = 0;

    typedef struct { int ch; int ts; } rec_t;
    typedef struct { int ch; int ts; int due; } evq_t;
    rec_t mq[$];
    evq_t mp[$];
    int edge_k = 0;
    int mtick, mnext, mpend, mwidth, mrem, movf;
    bit mpv;
    int mhv[NCH], mhts[NCH], mdiv[NCH], mcnt[NCH], mprev[NCH];

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural model of one clock edge, using the inputs applied before it.
    task automatic model_step();
        int lo;
        bit setov, full;
        evq_t keep[$];
        if (!rst_n) begin
            mtick = 0; mnext = SEC; mpend = 0; mpv = 0; mwidth = DEFW; mrem = 0; movf = 0;
            mq.delete(); mp.delete();
            for (int i = 0; i < NCH; i++) begin
                mhv[i] = 0; mhts[i] = 0; mdiv[i] = 0; mcnt[i] = 0; mprev[i] = 0;
            end
            return;
        end
        setov = 0;
        if (mtick == mnext) begin
            mrem = mwidth;
            mnext = mpv ? mpend : ((mnext + SEC) & MASK);
            mpv = 0;
        end else if (mrem > 0) mrem--;
        if (place_wr) begin mpend = int'(place_val); mpv = 1; end
        if (width_wr) mwidth = int'(width_val);
        full = (mq.size() == DEPTH);
        if (ts_rd && mq.size() > 0) void'(mq.pop_front());
        lo = -1;
        for (int i = 0; i < NCH; i++) if (mhv[i] != 0 && lo < 0) lo = i;
        if (lo >= 0) begin
            if (full) setov = 1;
            else mq.push_back('{lo, mhts[lo]});
            mhv[lo] = 0;
        end
        foreach (mp[j]) begin
            if (mp[j].due == edge_k) begin
                if (mhv[mp[j].ch] != 0) setov = 1;
                mhv[mp[j].ch] = 1;
                mhts[mp[j].ch] = mp[j].ts;
            end else keep.push_back(mp[j]);
        end
        mp = keep;
        if (setov) movf = 1; else if (ovf_clr) movf = 0;
        if (div_wr && int'(div_sel) < NCH) begin
            mdiv[div_sel] = int'(div_val); mcnt[div_sel] = 0;
        end
        mtick = (mtick + 1) & MASK;
        for (int c = 0; c < NCH; c++) begin
            int cur;
            bit ev;
            cur = int'(ref_in[c]);
            if (cur != 0 && mprev[c] == 0) begin
                ev = 0;
                if (mdiv[c] == 0) ev = 1;
                else begin
                    mcnt[c]++;
                    if (mcnt[c] == mdiv[c]) begin ev = 1; mcnt[c] = 0; end
                end
                if (ev) mp.push_back('{c, (mtick + 1) & MASK, edge_k + 2});
            end
            mprev[c] = cur;
        end
    endtask

    task automatic compare();
        check("R1", int'(tick_count), mtick, "tick_count");
        check("R7", int'(pps_out), (mrem != 0) ? 1 : 0, "pps_out");
        check("R4", int'(ts_valid), (mq.size() > 0) ? 1 : 0, "ts_valid");
        if (ts_valid && mq.size() > 0) begin
            check("R5", int'(ts_chan), mq[0].ch, "head channel");
            check("R2", int'(ts_time), mq[0].ts, "head time");
        end
        check("R6", int'(ts_ovf), movf, "ts_ovf");
    endtask

    task automatic cyc();
        @(negedge clk);
        model_step();
        compare();
        edge_k++;
        div_wr = 0; ts_rd = 0; ovf_clr = 0; place_wr = 0; width_wr = 0;
    endtask

    task automatic pulse_ch(int mask, int hi, int lo);
        ref_in = ref_in | NCH'(mask);
        repeat (hi) cyc();
        ref_in = ref_in & ~NCH'(mask);
        repeat (lo) cyc();
    endtask

    task automatic pop_one(output int ch, output int ts);
        int guard = 0;
        while (!ts_valid && guard < 20) begin cyc(); guard++; end
        ch = int'(ts_chan); ts = int'(ts_time);
        ts_rd = 1;
        cyc();
    endtask

    task automatic wait_rise(output int t);
        int guard = 0;
        while (!pps_out && guard < 70000) begin cyc(); guard++; end
        t = int'(tick_count);
    endtask

    task automatic measure(output int w);
        w = 0;
        while (pps_out && w < 300) begin w++; cyc(); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int te, ch, ts, ch_a, ts_a, n, t, w;
        bit seen;
        repeat (4) cyc();
        // R10 reset state
        check("R10", int'(ts_valid), 0, "valid in reset");
        check("R10", int'(ts_ovf), 0, "ovf in reset");
        check("R10", int'(pps_out), 0, "pps in reset");
        check("R1", int'(tick_count), 0, "tick in reset");
        rst_n = 1;
        repeat (3) cyc();

        // R2 single edge latency and time value
        ref_in[0] = 1'b1;
        cyc();
        te = int'(tick_count);
        cyc(); cyc();
        check("R2", int'(ts_valid), 0, "valid before e+3");
        cyc();
        check("R2", int'(ts_valid), 1, "valid after e+3");
        check("R2", int'(ts_time), (te + 1) & MASK, "time of single edge");
        check("R2", int'(ts_chan), 0, "channel of single edge");
        repeat (4) cyc();
        ref_in[0] = 1'b0;
        pop_one(ch, ts);
        repeat (6) cyc();
        check("R2", int'(ts_valid), 0, "held level gives one record");

        // R5 simultaneous edges
        pulse_ch(7, 2, 4);
        pop_one(ch_a, ts_a);
        check("R5", ch_a, 0, "first channel");
        pop_one(ch, ts);
        check("R5", ch, 1, "second channel");
        check("R5", ts, ts_a, "shared time second");
        pop_one(ch, ts);
        check("R5", ch, 2, "third channel");
        check("R5", ts, ts_a, "shared time third");

        // R3 divide by three on channel 1
        div_sel = 2'd1; div_val = 8'd3; div_wr = 1;
        cyc();
        repeat (7) pulse_ch(2, 2, 2);
        repeat (6) cyc();
        n = 0;
        while (ts_valid) begin pop_one(ch, ts); if (ch == 1) n++; end
        check("R3", n, 2, "records from seven edges at divisor 3");
        div_sel = 2'd1; div_val = 8'd0; div_wr = 1;
        cyc();

        // R6 queue full
        repeat (6) pulse_ch(4, 2, 2);
        repeat (6) cyc();
        check("R6", int'(ts_ovf), 1, "ovf after full queue");
        ovf_clr = 1;
        cyc();
        check("R6", int'(ts_ovf), 0, "ovf cleared");
        n = 0;
        while (ts_valid) begin pop_one(ch, ts); n++; end
        check("R4", n, DEPTH, "records kept at depth");
        ts_rd = 1;
        cyc();
        check("R4", int'(ts_valid), 0, "read on empty ignored");

        // R6 channel starved by its neighbours
        repeat (8) pulse_ch(7, 1, 1);
        repeat (6) cyc();
        check("R6", int'(ts_ovf), 1, "ovf after lost event");
        ovf_clr = 1;
        cyc();
        while (ts_valid) pop_one(ch, ts);

        // R7 R8 R9 output pulse placement
        place_val = 16'd5000; place_wr = 1;
        cyc();
        wait_rise(t);
        check("R7", t, SEC + 1, "first pulse start");
        measure(w);
        check("R7", w, DEFW, "default width");
        wait_rise(t);
        check("R8", t, 5001, "host placement");
        width_val = 8'd10; width_wr = 1;
        measure(w);
        check("R9", w, DEFW, "width during pulse unchanged");
        wait_rise(t);
        check("R8", t, 7001, "free-running re-arm");
        measure(w);
        check("R9", w, 10, "new width on next pulse");
        width_val = 8'd0; width_wr = 1;
        cyc();
        seen = 0;
        while (int'(tick_count) != 9100) begin cyc(); if (pps_out) seen = 1; end
        check("R7", int'(seen), 0, "zero width gives no pulse");
        width_val = 8'd50; width_wr = 1;
        place_val = 16'd65530; place_wr = 1;
        cyc();
        wait_rise(t);
        check("R8", t, 11001, "re-arm after zero-width firing");
        measure(w);
        wait_rise(t);
        check("R8", t, 65531, "placement near wrap");
        measure(w);
        check("R7", w, 50, "width across wrap");
        check("R1", int'(tick_count), (65531 + 50) & MASK, "tick after wrap");
        wait_rise(t);
        check("R8", t, (65530 + SEC + 1) & MASK, "re-arm modulo counter width");
        measure(w);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule